// File: doc/BRIEF.md
# Field Memory Read-Enable and Write-Reset Timing Generator

This block generates the display-side control strobes for a pair of video field memories. It runs from a line-locked pixel clock and watches two one-cycle input pulses: one that marks the start of each video line and one that marks the start of each field. From these it keeps a pixel position and a line number. It produces two active-high read enables, one for each memory, and a reset strobe for the write address pointer of the second memory.

Each read enable is the AND of two windows. The horizontal window is open over a fixed span of pixel positions. The vertical window is open between two programmable line numbers, and those numbers are clamped to the range allowed by the selected 50 Hz or 60 Hz standard. The first enable's vertical window can be moved against the second's by a small line offset, which supports median and noise filtering across lines. Each enable's horizontal timing can be delayed by zero to three pixel clocks, and the two delays are set independently.

The write-pointer reset strobe is produced by a two-state machine with the states WS_IDLE and WS_PULSE. The transition WS_IDLE to WS_PULSE is named START. It is taken on a field pulse when serial operation is selected, or on every second field pulse when single-memory (progressive) operation is selected. The transition WS_PULSE to WS_IDLE is named EXPIRE. It is taken when the strobe has lasted half a line period. No other transitions exist. Field pulses that arrive in WS_PULSE do not restart the strobe.

Top module: `fme_timing_gen`

## Requirements
- R1: After reset, rd_en1, rd_en2 and wptr_rst are low, the line number and pixel position are 0, and the field phase is "first".
- R2: A read enable is high only when its delayed horizontal window and its vertical window are both open, and it is low at all other times.
- R3: A line pulse sets the pixel position to 0 in the next cycle, and the position then counts up by one per clock, saturating. The horizontal window is open for positions H_START up to but not including H_STOP. With a delay code d (0 to 3, taken from dly_re1 or dly_re2), the read enable follows the window 1+d clocks later.
- R4: A field pulse sets the line number to 0, and it takes priority over a line pulse in the same cycle. Each other line pulse adds one to the line number, saturating. The vertical window of rd_en2 is open on lines L with Nr ≤ L < Nf.
- R5: Before use, Nr is clamped to [1, LIM−1] and Nf to [2, LIM]. LIM is MAX_LINE_50 when std_60=0 and MAX_LINE_60 when std_60=1. When the clamped Nr is not below the clamped Nf, both vertical windows stay closed.
- R6: The code off_sel shifts the vertical window of rd_en1 against that of rd_en2. Code 0 keeps it equal. Code 1 opens and closes it one line earlier, code 2 two lines earlier, and code 3 one line later.
- R7: With serial_mode=1 and the machine in WS_IDLE, every field pulse raises wptr_rst in the next cycle. This gives one strobe per field.
- R8: With serial_mode=0, only field pulses that arrive while the field phase is "first" raise wptr_rst. The phase flips on every field pulse. This gives one strobe per two fields.
- R9: wptr_rst stays high for exactly HALF_LINE clocks. A field pulse during the strobe neither lengthens it nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pulse | input | 1 | One-cycle line start marker |
| field_pulse | input | 1 | One-cycle field start marker |
| std_60 | input | 1 | 1 selects the 60 Hz line limit, 0 the 50 Hz limit |
| serial_mode | input | 1 | 1 = serial two-memory arrangement, 0 = single-memory/progressive |
| nr_line | input | LINE_W | Vertical window opening line |
| nf_line | input | LINE_W | Vertical window closing line |
| off_sel | input | 2 | rd_en1 vertical offset code (0 same, 1 one earlier, 2 two earlier, 3 one later) |
| dly_re1 | input | 2 | Horizontal delay of rd_en1 in clocks |
| dly_re2 | input | 2 | Horizontal delay of rd_en2 in clocks |
| rd_en1 | output | 1 | Read enable for field memory 1 |
| rd_en2 | output | 1 | Read enable for field memory 2 |
| wptr_rst | output | 1 | Write-pointer reset strobe for field memory 2 |

## Verification
The bench builds the block with a 24-clock line, a horizontal window from position 3 to 15, a 12-clock strobe, and line limits of 20 (50 Hz) and 14 (60 Hz), with 22 lines per field. With these values a whole field takes a few hundred clocks. The clamps at both ends, the empty window when Nr exceeds Nf, windows that touch line 0 or the last line, and several strobe periods in each memory mode can all be reached within a short run. The four delay codes fit inside the line without leaking into the next line, so the bench can count active lines per field for every offset code.

// File: rtl/fme_pkg.sv
package fme_pkg;

    // Vertical offset of read enable 1 relative to read enable 2
    typedef enum logic [1:0] {
        VOFF_SAME  = 2'd0,
        VOFF_LEAD1 = 2'd1,
        VOFF_LEAD2 = 2'd2,
        VOFF_LAG1  = 2'd3
    } voff_e;

    // Write-pointer reset strobe machine
    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_PULSE = 1'b1
    } wst_e;

endpackage

// File: rtl/fme_line_track.sv
module fme_line_track #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic              field_pulse,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);

    localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt <= '0;
        end else if (line_pulse) begin
            pix_cnt <= '0;
        end else if (pix_cnt != PIX_MAX) begin
            pix_cnt <= pix_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (field_pulse) begin
            line_cnt <= '0;
        end else if (line_pulse && (line_cnt != LINE_MAX)) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fme_vwin.sv
module fme_vwin
    import fme_pkg::*;
#(
    parameter int LINE_W      = 9,
    parameter int MAX_LINE_50 = 311,
    parameter int MAX_LINE_60 = 261
) (
    input  logic [LINE_W-1:0] line_cnt,
    input  logic              std_60,
    input  logic [LINE_W-1:0] nr_line,
    input  logic [LINE_W-1:0] nf_line,
    input  logic [1:0]        off_sel,
    output logic              vwin1,
    output logic              vwin2
);

    localparam int AW = LINE_W + 2;
    localparam logic [LINE_W-1:0] LIM50 = LINE_W'(MAX_LINE_50);
    localparam logic [LINE_W-1:0] LIM60 = LINE_W'(MAX_LINE_60);
    localparam logic [LINE_W-1:0] ONE   = LINE_W'(1);
    localparam logic [LINE_W-1:0] TWO   = LINE_W'(2);

    logic [LINE_W-1:0] lim;
    logic [LINE_W-1:0] nr_c;
    logic [LINE_W-1:0] nf_c;
    logic [AW-1:0]     lo;
    logic [AW-1:0]     hi;
    logic [AW-1:0]     line_ext;
    logic [AW-1:0]     adj1;
    voff_e             off;

    always_comb begin
        lim = std_60 ? LIM60 : LIM50;
        if (nr_line < ONE)              nr_c = ONE;
        else if (nr_line > (lim - ONE)) nr_c = lim - ONE;
        else                            nr_c = nr_line;
        if (nf_line < TWO)              nf_c = TWO;
        else if (nf_line > lim)         nf_c = lim;
        else                            nf_c = nf_line;
    end

    // Shifted comparison domain: every position is biased by one so a
    // lagging window never needs a negative line number.
    always_comb begin
        lo       = AW'(nr_c) + AW'(1);
        hi       = AW'(nf_c) + AW'(1);
        line_ext = AW'(line_cnt);
        off      = voff_e'(off_sel);
        unique case (off)
            VOFF_SAME:  adj1 = line_ext + AW'(1);
            VOFF_LEAD1: adj1 = line_ext + AW'(2);
            VOFF_LEAD2: adj1 = line_ext + AW'(3);
            VOFF_LAG1:  adj1 = line_ext;
            default:    adj1 = line_ext + AW'(1);
        endcase
    end

    assign vwin2 = ((line_ext + AW'(1)) >= lo) && ((line_ext + AW'(1)) < hi);
    assign vwin1 = (adj1 >= lo) && (adj1 < hi);

endmodule

// File: rtl/fme_hdelay.sv
module fme_hdelay #(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     din,
    input  logic [$clog2(DEPTH)-1:0] sel,
    output logic                     dout
);

    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= 1'b0;
        else        stage[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i] <= 1'b0;
            else        stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[sel];

endmodule

// File: rtl/fme_wrst_fsm.sv
module fme_wrst_fsm
    import fme_pkg::*;
#(
    parameter int HALF_LINE = 432
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_pulse,
    input  logic serial_mode,
    output logic strobe
);

    localparam int CNT_W = (HALF_LINE > 1) ? $clog2(HALF_LINE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_LINE - 1);

    wst_e             st;
    wst_e             st_nxt;
    logic [CNT_W-1:0] cnt;
    logic             phase;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= WS_IDLE;
        else        st <= st_nxt;
    end

    // Transitions: START and EXPIRE
    always_comb begin
        st_nxt = st;
        unique case (st)
            WS_IDLE:  if (field_pulse && (serial_mode || !phase)) st_nxt = WS_PULSE;
            WS_PULSE: if (cnt == LAST)                            st_nxt = WS_IDLE;
            default:  st_nxt = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (st == WS_PULSE) cnt <= cnt + 1'b1;
        else                     cnt <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           phase <= 1'b0;
        else if (field_pulse) phase <= ~phase;
    end

    // Outputs
    always_comb begin
        unique case (st)
            WS_PULSE: strobe = 1'b1;
            default:  strobe = 1'b0;
        endcase
    end

endmodule

// File: rtl/fme_timing_gen.sv
module fme_timing_gen #(
    parameter int PIX_W       = 11,
    parameter int LINE_W      = 9,
    parameter int H_START     = 132,
    parameter int H_STOP      = 852,
    parameter int HALF_LINE   = 432,
    parameter int MAX_LINE_50 = 311,
    parameter int MAX_LINE_60 = 261
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic              field_pulse,
    input  logic              std_60,
    input  logic              serial_mode,
    input  logic [LINE_W-1:0] nr_line,
    input  logic [LINE_W-1:0] nf_line,
    input  logic [1:0]        off_sel,
    input  logic [1:0]        dly_re1,
    input  logic [1:0]        dly_re2,
    output logic              rd_en1,
    output logic              rd_en2,
    output logic              wptr_rst
);

    localparam logic [PIX_W-1:0] HS = PIX_W'(H_START);
    localparam logic [PIX_W-1:0] HE = PIX_W'(H_STOP);

    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic              hwin;
    logic              vwin1;
    logic              vwin2;

    fme_line_track #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_pulse  (line_pulse),
        .field_pulse (field_pulse),
        .pix_cnt     (pix_cnt),
        .line_cnt    (line_cnt)
    );

    fme_vwin #(
        .LINE_W      (LINE_W),
        .MAX_LINE_50 (MAX_LINE_50),
        .MAX_LINE_60 (MAX_LINE_60)
    ) u_vwin (
        .line_cnt (line_cnt),
        .std_60   (std_60),
        .nr_line  (nr_line),
        .nf_line  (nf_line),
        .off_sel  (off_sel),
        .vwin1    (vwin1),
        .vwin2    (vwin2)
    );

    assign hwin = (pix_cnt >= HS) && (pix_cnt < HE);

    fme_hdelay #(.DEPTH(4)) u_dly1 (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hwin && vwin1),
        .sel   (dly_re1),
        .dout  (rd_en1)
    );

    fme_hdelay #(.DEPTH(4)) u_dly2 (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hwin && vwin2),
        .sel   (dly_re2),
        .dout  (rd_en2)
    );

    fme_wrst_fsm #(.HALF_LINE(HALF_LINE)) u_wrst (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_pulse (field_pulse),
        .serial_mode (serial_mode),
        .strobe      (wptr_rst)
    );

endmodule

// File: rtl/fme_timing_chk.sv
module fme_timing_chk #(
    parameter int PIX_W     = 11,
    parameter int H_START   = 132,
    parameter int H_STOP    = 852,
    parameter int HALF_LINE = 432
) (
    input logic       clk,
    input logic       rst_n,
    input logic       line_pulse,
    input logic       field_pulse,
    input logic       serial_mode,
    input logic [1:0] dly_re2,
    input logic       rd_en2,
    input logic       wptr_rst
);

    localparam int HW = $clog2(HALF_LINE + 2) + 1;
    localparam logic [PIX_W-1:0] HS = PIX_W'(H_START);
    localparam logic [PIX_W-1:0] HE = PIX_W'(H_STOP);

    logic [PIX_W-1:0] c_pix;
    logic [PIX_W-1:0] c_pix_prev;
    logic [HW-1:0]    hi_cnt;
    logic             c_phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_pix      <= '0;
            c_pix_prev <= '0;
            hi_cnt     <= '0;
            c_phase    <= 1'b0;
        end else begin
            c_pix_prev <= c_pix;
            if (line_pulse)       c_pix <= '0;
            else if (c_pix != '1) c_pix <= c_pix + 1'b1;
            hi_cnt <= wptr_rst ? hi_cnt + 1'b1 : '0;
            if (field_pulse) c_phase <= ~c_phase;
        end
    end

    AST_RE2_HWIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en2 && dly_re2 == 2'd0) |-> (c_pix_prev >= HS && c_pix_prev < HE)); // R3

    AST_SERIAL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && field_pulse && !wptr_rst) |=> wptr_rst); // R7

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && field_pulse && !wptr_rst && !c_phase) |=> wptr_rst); // R8

    AST_SINGLE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && field_pulse && !wptr_rst && c_phase) |=> !wptr_rst); // R8

    AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_rst |-> (hi_cnt < HW'(HALF_LINE))); // R9

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wptr_rst) |-> (hi_cnt == HW'(HALF_LINE))); // R9

endmodule

bind fme_timing_gen fme_timing_chk #(
    .PIX_W     (PIX_W),
    .H_START   (H_START),
    .H_STOP    (H_STOP),
    .HALF_LINE (HALF_LINE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_pulse  (line_pulse),
    .field_pulse (field_pulse),
    .serial_mode (serial_mode),
    .dly_re2     (dly_re2),
    .rd_en2      (rd_en2),
    .wptr_rst    (wptr_rst)
);

// File: tb/sim_fme_timing_gen.sv
`timescale 1ns/1ps
module sim_fme_timing_gen;

    localparam int PW = 6, LW = 9, HS = 3, HE = 15, HALF = 12;
    localparam int M50 = 20, M60 = 14, LLEN = 24, FLINES = 22, NSCEN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_pulse = 1'b0, field_pulse = 1'b0, std_60 = 1'b0, serial_mode = 1'b1;
    logic [LW-1:0] nr_line = '0, nf_line = '0;
    logic [1:0] off_sel = '0, dly_re1 = '0, dly_re2 = '0;
    logic rd_en1, rd_en2, wptr_rst;

    always #2.5 clk = ~clk;

    fme_timing_gen #(
        .PIX_W(PW), .LINE_W(LW), .H_START(HS), .H_STOP(HE), .HALF_LINE(HALF),
        .MAX_LINE_50(M50), .MAX_LINE_60(M60)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .field_pulse(field_pulse),
        .std_60(std_60), .serial_mode(serial_mode), .nr_line(nr_line), .nf_line(nf_line),
        .off_sel(off_sel), .dly_re1(dly_re1), .dly_re2(dly_re2),
        .rd_en1(rd_en1), .rd_en2(rd_en2), .wptr_rst(wptr_rst)
    );

    int errors = 0, checks = 0, cyc = 0, scen = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_pix = 0, m_line = 0, m_scnt = 0;
    bit m_phase = 0;
    bit h1[4], h2[4];
    int s_lo, s_hi, s_k1, s_lim;
    bit s_valid = 0;
    bit seen1[32], seen2[32];

    function automatic int clamp_lo(input int nr, input int lim);
        if (nr < 1) return 1;
        if (nr > lim - 1) return lim - 1;
        return nr;
    endfunction
    function automatic int clamp_hi(input int nf, input int lim);
        if (nf < 2) return 2;
        if (nf > lim) return lim;
        return nf;
    endfunction
    function automatic int off_k(input int code);
        case (code)
            0: return 0;
            1: return 1;
            2: return 2;
            default: return -1;
        endcase
    endfunction
    function automatic bit in_win(input int ln, input int k);
        int lim, lo, hi;
        lim = std_60 ? M60 : M50;
        lo = clamp_lo(int'(nr_line), lim);
        hi = clamp_hi(int'(nf_line), lim);
        return (ln + k >= lo) && (ln + k < hi);
    endfunction

    always @(posedge clk) begin
        bit hw, fire;
        if (!rst_n) begin
            m_pix = 0; m_line = 0; m_scnt = 0; m_phase = 0; s_valid = 0;
            for (int i = 0; i < 4; i++) begin h1[i] = 0; h2[i] = 0; end
        end else begin
            hw = (m_pix >= HS) && (m_pix < HE);
            for (int i = 3; i > 0; i--) begin h1[i] = h1[i-1]; h2[i] = h2[i-1]; end
            h1[0] = hw && in_win(m_line, off_k(int'(off_sel)));
            h2[0] = hw && in_win(m_line, 0);
            // strobe model
            fire = field_pulse && (serial_mode || !m_phase);
            if (m_scnt > 0) m_scnt--;
            else if (fire) m_scnt = HALF;
            if (field_pulse) m_phase = ~m_phase;
            // per-field line counts
            if (field_pulse) begin
                if (s_valid) begin
                    int e1, e2, o1, o2;
                    e1 = 0; e2 = 0; o1 = 0; o2 = 0;
                    for (int l = 0; l < FLINES; l++) begin
                        if (l + s_k1 >= s_lo && l + s_k1 < s_hi) e1++;
                        if (l >= s_lo && l < s_hi) e2++;
                        o1 += seen1[l]; o2 += seen2[l];
                    end
                    chk(o2 == e2, "R4 R5 rd_en2 active lines per field", o2, e2);
                    chk(o1 == e1, "R5 R6 rd_en1 active lines per field", o1, e1);
                end
                s_lim = std_60 ? M60 : M50;
                s_lo = clamp_lo(int'(nr_line), s_lim);
                s_hi = clamp_hi(int'(nf_line), s_lim);
                s_k1 = off_k(int'(off_sel));
                s_valid = 1;
                for (int l = 0; l < 32; l++) begin seen1[l] = 0; seen2[l] = 0; end
            end
            if (field_pulse) m_line = 0;
            else if (line_pulse && m_line < 511) m_line++;
            if (line_pulse) m_pix = 0;
            else if (m_pix < 63) m_pix++;
        end
    end

    // Compare on every clock, away from the active edge
    bit prev_ws = 0;
    int last_rise = -1, last_rise_scen = -1, rise_at = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(rd_en1 == h1[dly_re1], "R2 R3 R6 rd_en1 per-cycle", rd_en1, h1[dly_re1]);
            chk(rd_en2 == h2[dly_re2], "R2 R3 R4 rd_en2 per-cycle", rd_en2, h2[dly_re2]);
            chk(wptr_rst == (m_scnt > 0), "R7 R8 R9 wptr_rst per-cycle", wptr_rst, m_scnt > 0);
            if (m_line < 32) begin
                if (rd_en1) seen1[m_line] = 1;
                if (rd_en2) seen2[m_line] = 1;
            end
            if (wptr_rst && !prev_ws) begin
                if (last_rise_scen == scen) begin
                    int expp;
                    expp = (serial_mode ? 1 : 2) * FLINES * LLEN;
                    chk(cyc - last_rise == expp,
                        serial_mode ? "R7 strobe period" : "R8 strobe period",
                        cyc - last_rise, expp);
                end
                last_rise = cyc; last_rise_scen = scen; rise_at = cyc;
            end
            if (!wptr_rst && prev_ws)
                chk(cyc - rise_at == HALF, "R9 strobe width", cyc - rise_at, HALF);
            prev_ws = wptr_rst;
        end
    end

    task automatic set_scen(input int s);
        case (s)
            0: begin std_60 = 0; serial_mode = 1; nr_line = 5;   nf_line = 10;  dly_re1 = 0; dly_re2 = 0; off_sel = 0; end
            1: begin std_60 = 0; serial_mode = 1; nr_line = 5;   nf_line = 10;  dly_re1 = 1; dly_re2 = 2; off_sel = 1; end
            2: begin std_60 = 0; serial_mode = 1; nr_line = 5;   nf_line = 10;  dly_re1 = 3; dly_re2 = 0; off_sel = 2; end
            3: begin std_60 = 0; serial_mode = 1; nr_line = 5;   nf_line = 10;  dly_re1 = 2; dly_re2 = 3; off_sel = 3; end
            4: begin std_60 = 0; serial_mode = 1; nr_line = 0;   nf_line = 400; dly_re1 = 0; dly_re2 = 1; off_sel = 1; end
            5: begin std_60 = 1; serial_mode = 1; nr_line = 300; nf_line = 300; dly_re1 = 1; dly_re2 = 1; off_sel = 0; end
            6: begin std_60 = 0; serial_mode = 1; nr_line = 12;  nf_line = 6;   dly_re1 = 0; dly_re2 = 0; off_sel = 3; end
            7: begin std_60 = 0; serial_mode = 0; nr_line = 3;   nf_line = 18;  dly_re1 = 0; dly_re2 = 0; off_sel = 0; end
            8: begin std_60 = 1; serial_mode = 0; nr_line = 2;   nf_line = 13;  dly_re1 = 2; dly_re2 = 1; off_sel = 2; end
            default: begin std_60 = 1; serial_mode = 1; nr_line = 1; nf_line = 2; dly_re1 = 0; dly_re2 = 0; off_sel = 3; end
        endcase
    endtask

    task automatic drive_field();
        for (int l = 0; l < FLINES; l++) begin
            for (int p = 0; p < LLEN; p++) begin
                line_pulse  = (p == 0);
                field_pulse = (p == 0) && (l == 0);
                @(negedge clk);
            end
        end
        line_pulse = 0; field_pulse = 0;
    endtask

    initial begin
        set_scen(0);
        repeat (5) @(negedge clk);
        chk(rd_en1 == 0 && rd_en2 == 0 && wptr_rst == 0, "R1 outputs low in reset",
            {rd_en1, rd_en2, wptr_rst}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(rd_en1 == 0 && rd_en2 == 0 && wptr_rst == 0, "R1 outputs low after reset",
            {rd_en1, rd_en2, wptr_rst}, 0);
        for (int s = 0; s < NSCEN; s++) begin
            set_scen(s);
            scen = s;
            for (int f = 0; f < 4; f++) drive_field();
        end
        drive_field();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 5);
        errors++; checks++; done = 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule